// File: doc/BRIEF.md
# DMA Controller Control-Port Decoder

This block handles the control half of a four-channel DMA controller's register map. The CPU side presents one access at a time as a write enable, a read enable, a 3-bit control index and a data byte. Index 0 of this block corresponds to control address 8 of the controller, and index 7 corresponds to address 15. From these accesses the block keeps a command register, an 8-bit status register, an 8-bit mask register and one mode byte per channel. It also issues one-cycle strobes that tell the separate address/count block to reset its byte pointer or to perform a master reset.

The status register holds two kinds of per-channel state:
- **Terminal-count flags** in bits 3..0. A channel's per-cycle terminal-count input sets its flag. A status read clears these flags.
- **Request flags** in bits 7..4. Software request writes and external hold/release inputs set and clear them.

The transfer engine outside the block uses the mask, the request flags and the mode bytes to decide which channel to serve. Address and count storage and the data movement itself are not part of this block.

Top module: `dma_ctl_decoder`

## Requirements
- R1: After reset, the block shows status 0x00, command 0x00, mask 0xFF and all mode bytes 0x00, with both strobes low.
- R2: A write to index 0 loads the command register when the data byte has no bit of 0xFB set, so only 0x00 and 0x04 are accepted. Any other value leaves the command register unchanged.
- R3: A write to index 1 uses data[1:0] as the channel and data[2] as the set/clear value. It copies data[2] into status bit (channel+4) and clears status bit (channel).
- R4: A write to index 2 sets mask bit data[1:0] when data[2] is 1 and clears it when data[2] is 0. The other mask bits are unchanged.
- R5: A write to index 3 stores the full data byte as the mode of channel data[1:0]. Channel c's mode appears at mode_q[8c+7:8c]. No other write changes any mode byte.
- R6: A write to index 4 or index 5 raises ptr_clr for exactly the cycle after the write.
- R7: A write to index 5 clears status and command and sets all 8 mask bits. It raises mreset_stb for the cycle after the write and leaves the mode bytes unchanged.
- R8: A write to index 6 clears all 8 mask bits. A write to index 7 loads the mask from the data byte.
- R9: rd_data is combinational. A read at index 0 returns status, and at the clock edge status bits 3..0 are cleared while bits 7..4 are kept. A read at index 7 returns the mask. Every other read, and every cycle without a read, returns 0x00.
- R10: hold_req[c] sets status bit (c+4) and rel_req[c] clears it. If both are high, the release wins. Both override a same-cycle index-1 write to that channel.
- R11: tc_in[c] sets status bit c. This takes priority over a same-cycle status read clear and over an index-1 clear.
- R12: A master reset write takes priority over every same-cycle hold, release and terminal-count input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write access this cycle |
| rd_en | input | 1 | Read access this cycle |
| ctl_idx | input | 3 | Control index (0 = address 8 … 7 = address 15) |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data, combinational |
| hold_req | input | 4 | Per-channel external request hold |
| rel_req | input | 4 | Per-channel external request release |
| tc_in | input | 4 | Per-channel terminal-count pulse |
| cmd_q | output | 8 | Command register |
| status_q | output | 8 | Status register |
| mask_q | output | 8 | Mask register |
| mode_q | output | 32 | Mode bytes, channel c at bits 8c+7:8c |
| ptr_clr | output | 1 | Byte-pointer clear strobe |
| mreset_stb | output | 1 | Master reset strobe |

## Verification
The hardest situations to reach are same-cycle collisions on one status bit. Examples are a status read that would clear a terminal-count flag while that channel's terminal-count input fires, and a software request write racing external hold and release on the same channel. Random stimulus keeps hold, release and terminal-count inputs active at a moderate rate while reads and writes hit all eight indices, so such collisions occur repeatedly. Directed steps also force each collision once, along with a master reset arriving together with the external inputs.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

   typedef enum logic [2:0] {
      IX_CMD   = 3'd0,
      IX_REQ   = 3'd1,
      IX_SMASK = 3'd2,
      IX_MODE  = 3'd3,
      IX_PCLR  = 3'd4,
      IX_MRST  = 3'd5,
      IX_MCLR  = 3'd6,
      IX_MLOAD = 3'd7
   } ctl_idx_e;

   typedef struct packed {
      logic cmd;
      logic req;
      logic smask;
      logic mode;
      logic pclr;
      logic mrst;
      logic mclr;
      logic mload;
   } wr_evt_t;

   typedef struct packed {
      logic status;
      logic mask;
   } rd_evt_t;

endpackage

// File: rtl/dmactl_decode.sv
module dmactl_decode
   import dmactl_pkg::*;
(
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [2:0] idx,
   output wr_evt_t    wev,
   output rd_evt_t    rev
);

   always_comb begin
      wev = '0;
      if (wr_en) begin
         case (ctl_idx_e'(idx))
            IX_CMD:   wev.cmd   = 1'b1;
            IX_REQ:   wev.req   = 1'b1;
            IX_SMASK: wev.smask = 1'b1;
            IX_MODE:  wev.mode  = 1'b1;
            IX_PCLR:  wev.pclr  = 1'b1;
            IX_MRST:  wev.mrst  = 1'b1;
            IX_MCLR:  wev.mclr  = 1'b1;
            default:  wev.mload = 1'b1;
         endcase
      end
   end

   always_comb begin
      rev.status = rd_en && (ctl_idx_e'(idx) == IX_CMD);
      rev.mask   = rd_en && (ctl_idx_e'(idx) == IX_MLOAD);
   end

endmodule

// File: rtl/dmactl_status.sv
module dmactl_status #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_wr,
   input  logic              mrst,
   input  logic              rd_clr,
   input  logic [CH_W-1:0]   sel,
   input  logic              req_val,
   input  logic [NUM_CH-1:0] hold_req,
   input  logic [NUM_CH-1:0] rel_req,
   input  logic [NUM_CH-1:0] tc_in,
   output logic [DATA_W-1:0] status
);

   logic [NUM_CH-1:0] tc_flag;
   logic [NUM_CH-1:0] rq_flag;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      assign hit = req_wr && (sel == CH_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           rq_flag[c] <= 1'b0;
         else if (mrst)        rq_flag[c] <= 1'b0;
         else if (rel_req[c])  rq_flag[c] <= 1'b0;
         else if (hold_req[c]) rq_flag[c] <= 1'b1;
         else if (hit)         rq_flag[c] <= req_val;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          tc_flag[c] <= 1'b0;
         else if (mrst)       tc_flag[c] <= 1'b0;
         else if (tc_in[c])   tc_flag[c] <= 1'b1;
         else if (hit)        tc_flag[c] <= 1'b0;
         else if (rd_clr)     tc_flag[c] <= 1'b0;
      end

      // R11: terminal count always lands unless a master reset collides
      a_r11_tc_sets : assert property (@(posedge clk) disable iff (!rst_n)
         (tc_in[c] && !mrst) |=> status[c]);

      // R10: release dominates hold and software request
      a_r10_release_wins : assert property (@(posedge clk) disable iff (!rst_n)
         (rel_req[c] && !mrst) |=> !status[c+NUM_CH]);

      // R12: master reset dominates the external inputs
      a_r12_mrst_clears : assert property (@(posedge clk) disable iff (!rst_n)
         mrst |=> (!status[c] && !status[c+NUM_CH]));
   end

   if (DATA_W > 2*NUM_CH) begin : g_pad
      assign status = {{(DATA_W-2*NUM_CH){1'b0}}, rq_flag, tc_flag};
   end else begin : g_nopad
      assign status = {rq_flag, tc_flag};
   end

endmodule

// File: rtl/dmactl_mask.sv
module dmactl_mask #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smask,
   input  logic              mrst,
   input  logic              mclr,
   input  logic              mload,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] mask
);

   logic [CH_W-1:0] bit_sel;
   logic            bit_val;
   assign bit_sel = data[CH_W-1:0];
   assign bit_val = data[CH_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask <= '1;
      else if (mrst)   mask <= '1;
      else if (mclr)   mask <= '0;
      else if (mload)  mask <= data;
      else if (smask)  mask[bit_sel] <= bit_val;
   end

   a_r7_mask_all_ones : assert property (@(posedge clk) disable iff (!rst_n)
      mrst |=> (mask == {DATA_W{1'b1}}));

   a_r8_mask_cleared : assert property (@(posedge clk) disable iff (!rst_n)
      mclr |=> (mask == '0));

   a_r4_mask_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !(smask || mrst || mclr || mload) |=> $stable(mask));

endmodule

// File: rtl/dmactl_mode_bank.sv
module dmactl_mode_bank #(
   parameter int NUM_CH = 4,
   parameter int DATA_W = 8,
   localparam int CH_W  = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mode_wr,
   input  logic [DATA_W-1:0]        data,
   output logic [NUM_CH*DATA_W-1:0] mode_flat
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
      logic [DATA_W-1:0] mode_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mode_r <= '0;
         else if (mode_wr && (data[CH_W-1:0] == CH_W'(c)))
            mode_r <= data;
      end
      assign mode_flat[c*DATA_W +: DATA_W] = mode_r;
   end

   a_r5_mode_kept : assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr |=> $stable(mode_flat));

endmodule

// File: rtl/dma_ctl_decoder.sv
module dma_ctl_decoder
   import dmactl_pkg::*;
#(
   parameter int          NUM_CH      = 4,
   parameter int          DATA_W      = 8,
   parameter logic [7:0]  CMD_OK_BITS = 8'h04,
   localparam int         CH_W        = $clog2(NUM_CH),
   localparam int         MODE_W      = NUM_CH * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [2:0]        ctl_idx,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NUM_CH-1:0] hold_req,
   input  logic [NUM_CH-1:0] rel_req,
   input  logic [NUM_CH-1:0] tc_in,
   output logic [DATA_W-1:0] cmd_q,
   output logic [DATA_W-1:0] status_q,
   output logic [DATA_W-1:0] mask_q,
   output logic [MODE_W-1:0] mode_q,
   output logic              ptr_clr,
   output logic              mreset_stb
);

   if (DATA_W < 2*NUM_CH) begin : g_bad_width
      $error("status of two bits per channel must fit the data byte");
   end
   if ((1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("channel count must be a power of two");
   end
   if (CH_W + 1 > DATA_W) begin : g_bad_sel
      $error("channel select plus set bit must fit the data byte");
   end

   wr_evt_t wev;
   rd_evt_t rev;

   dmactl_decode u_dec (
      .wr_en (wr_en),
      .rd_en (rd_en),
      .idx   (ctl_idx),
      .wev   (wev),
      .rev   (rev)
   );

   dmactl_status #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_wr   (wev.req),
      .mrst     (wev.mrst),
      .rd_clr   (rev.status),
      .sel      (wr_data[CH_W-1:0]),
      .req_val  (wr_data[CH_W]),
      .hold_req (hold_req),
      .rel_req  (rel_req),
      .tc_in    (tc_in),
      .status   (status_q)
   );

   dmactl_mask #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .smask (wev.smask),
      .mrst  (wev.mrst),
      .mclr  (wev.mclr),
      .mload (wev.mload),
      .data  (wr_data),
      .mask  (mask_q)
   );

   dmactl_mode_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_modes (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_wr   (wev.mode),
      .data      (wr_data),
      .mode_flat (mode_q)
   );

   localparam logic [DATA_W-1:0] CMD_BAD = ~DATA_W'(CMD_OK_BITS);
   logic cmd_ok;
   assign cmd_ok = (wr_data & CMD_BAD) == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cmd_q <= '0;
      else if (wev.mrst)           cmd_q <= '0;
      else if (wev.cmd && cmd_ok)  cmd_q <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_clr    <= 1'b0;
         mreset_stb <= 1'b0;
      end else begin
         ptr_clr    <= wev.pclr || wev.mrst;
         mreset_stb <= wev.mrst;
      end
   end

   always_comb begin
      if (rev.status)     rd_data = status_q;
      else if (rev.mask)  rd_data = mask_q;
      else                rd_data = '0;
   end

   // R2: a command with a forbidden bit set leaves the register alone
   a_r2_cmd_reject : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ctl_idx == 3'd0 && (wr_data & CMD_BAD) != '0) |=> $stable(cmd_q));

   // R6: pointer strobe only follows an index-4 or index-5 write
   a_r6_ptr_strobe : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (ctl_idx == 3'd4 || ctl_idx == 3'd5)) |=> ptr_clr);

   a_r6_ptr_single : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (ctl_idx == 3'd4 || ctl_idx == 3'd5)) |=> !ptr_clr);

   // R9: read clears the terminal-count nibble when nothing re-sets it
   a_r9_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && ctl_idx == 3'd0 && tc_in == '0) |=> (status_q[NUM_CH-1:0] == '0));

   // R7: master reset leaves command and status at zero
   a_r7_mrst_cmd : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ctl_idx == 3'd5) |=> (cmd_q == '0 && status_q == '0 && mreset_stb));

endmodule

// File: tb/dma_ctl_decoder_test.sv
module dma_ctl_decoder_test;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0]  ctl_idx = '0;
   logic [7:0]  wr_data = '0;
   logic [3:0]  hold_req = '0, rel_req = '0, tc_in = '0;
   logic [7:0]  rd_data, cmd_q, status_q, mask_q;
   logic [31:0] mode_q;
   logic        ptr_clr, mreset_stb;

   int total = 0, bad = 0;
   bit done = 0;

   logic [7:0]  m_st, m_mask, m_cmd;
   logic [31:0] m_mode;
   logic        m_ptr, m_mrs;

   always #(CLK_P/2) clk = ~clk;

   dma_ctl_decoder uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .ctl_idx(ctl_idx), .wr_data(wr_data), .rd_data(rd_data),
      .hold_req(hold_req), .rel_req(rel_req), .tc_in(tc_in),
      .cmd_q(cmd_q), .status_q(status_q), .mask_q(mask_q),
      .mode_q(mode_q), .ptr_clr(ptr_clr), .mreset_stb(mreset_stb)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic re, input logic [2:0] ix,
                                           input logic [7:0] st, input logic [7:0] mk);
      if (re && ix == 3'd0)      return st;
      else if (re && ix == 3'd7) return mk;
      else                       return 8'h00;
   endfunction

   function automatic logic [7:0] next_status(input logic [7:0] st, input logic we,
         input logic re, input logic [2:0] ix, input logic [7:0] d,
         input logic [3:0] h, input logic [3:0] r, input logic [3:0] t);
      logic [7:0] n = st;
      if (re && ix == 3'd0) n[3:0] = 4'h0;
      if (we && ix == 3'd1) begin
         n[d[1:0]+4] = d[2];
         n[d[1:0]]   = 1'b0;
      end
      for (int c = 0; c < 4; c++) begin
         if (h[c]) n[c+4] = 1'b1;
         if (r[c]) n[c+4] = 1'b0;
         if (t[c]) n[c]   = 1'b1;
      end
      if (we && ix == 3'd5) n = 8'h00;
      return n;
   endfunction

   task automatic check_state();
      chk("R3 R10 R11 R12 status", {24'h0, status_q}, {24'h0, m_st});
      chk("R4 R8 mask", {24'h0, mask_q}, {24'h0, m_mask});
      chk("R2 command", {24'h0, cmd_q}, {24'h0, m_cmd});
      chk("R5 mode", mode_q, m_mode);
      chk("R6 ptr_clr", {31'h0, ptr_clr}, {31'h0, m_ptr});
      chk("R7 mreset_stb", {31'h0, mreset_stb}, {31'h0, m_mrs});
   endtask

   task automatic step(input logic we, input logic re, input logic [2:0] ix,
                       input logic [7:0] d, input logic [3:0] h,
                       input logic [3:0] r, input logic [3:0] t);
      @(negedge clk);
      check_state();
      wr_en = we; rd_en = re; ctl_idx = ix; wr_data = d;
      hold_req = h; rel_req = r; tc_in = t;
      #1;
      chk("R9 rd_data", {24'h0, rd_data}, {24'h0, exp_read(re, ix, m_st, m_mask)});
      m_st = next_status(m_st, we, re, ix, d, h, r, t);
      if (we) begin
         case (ix)
            3'd0: if ((d & 8'hFB) == 8'h00) m_cmd = d;
            3'd2: m_mask[d[1:0]] = d[2];
            3'd3: m_mode[d[1:0]*8 +: 8] = d;
            3'd5: begin m_mask = 8'hFF; m_cmd = 8'h00; end
            3'd6: m_mask = 8'h00;
            3'd7: m_mask = d;
            default: ;
         endcase
      end
      m_ptr = we && (ix == 3'd4 || ix == 3'd5);
      m_mrs = we && (ix == 3'd5);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      seed = 32'd1234;
      void'($urandom(seed));
      m_st = 8'h00; m_mask = 8'hFF; m_cmd = 8'h00; m_mode = '0;
      m_ptr = 1'b0; m_mrs = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset values
      @(negedge clk);
      chk("R1 reset status", {24'h0, status_q}, 32'h00);
      chk("R1 reset mask", {24'h0, mask_q}, 32'hFF);
      chk("R1 reset command", {24'h0, cmd_q}, 32'h00);
      chk("R1 reset modes", mode_q, 32'h0);
      chk("R1 reset strobes", {30'h0, ptr_clr, mreset_stb}, 32'h0);

      // R2 directed: accepted 0x04, rejected 0x05 and 0x80, accepted 0x00
      step(1, 0, 3'd0, 8'h04, 0, 0, 0);
      step(1, 0, 3'd0, 8'h05, 0, 0, 0);
      step(1, 0, 3'd0, 8'h80, 0, 0, 0);
      step(0, 0, 3'd0, 8'h00, 0, 0, 0);
      chk("R2 command 0x04 kept", {24'h0, cmd_q}, 32'h04);
      step(1, 0, 3'd0, 8'h00, 0, 0, 0);
      // R5 modes on channels 3 and 1
      step(1, 0, 3'd3, 8'hA7, 0, 0, 0);
      step(1, 0, 3'd3, 8'h55, 0, 0, 0);
      // R3 software request set on ch2, then clear
      step(1, 0, 3'd1, 8'h06, 0, 0, 4'b0100);
      step(0, 0, 3'd0, 8'h00, 0, 0, 0);
      chk("R3 request bit set, tc kept by R11", {24'h0, status_q}, 32'h44);
      step(1, 0, 3'd1, 8'h02, 0, 0, 0);
      // R11 tc colliding with status read
      step(0, 0, 3'd0, 8'h00, 0, 0, 4'b0001);
      step(0, 1, 3'd0, 8'h00, 0, 0, 4'b0010);
      step(0, 0, 3'd0, 8'h00, 0, 0, 0);
      chk("R11 tc beats read clear", {24'h0, status_q}, 32'h02);
      // R10 hold and release together, and against software write
      step(1, 0, 3'd1, 8'h04, 4'b0001, 4'b0001, 0);
      step(1, 0, 3'd1, 8'h01, 4'b0010, 0, 0);
      step(0, 1, 3'd7, 8'h00, 0, 0, 0);
      chk("R10 release wins, hold beats sw clear", {24'h0, status_q}, 32'h20);
      // R4 / R8 mask operations
      step(1, 0, 3'd6, 8'h00, 0, 0, 0);
      step(1, 0, 3'd2, 8'h07, 0, 0, 0);
      step(1, 0, 3'd7, 8'h3C, 0, 0, 0);
      step(0, 1, 3'd7, 8'h00, 0, 0, 0);
      // R6 pointer clear, R12 master reset with live inputs
      step(1, 0, 3'd4, 8'h00, 0, 0, 0);
      step(1, 0, 3'd5, 8'h00, 4'hF, 0, 4'hF);
      step(0, 0, 3'd0, 8'h00, 0, 0, 0);
      chk("R12 master reset beats inputs", {24'h0, status_q}, 32'h00);
      chk("R7 modes survive master reset", mode_q[31:24], 32'hA7);

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         logic we, re;
         logic [2:0] ix;
         logic [7:0] d;
         logic [3:0] h, r, t;
         we = ($urandom % 2) == 0;
         re = ($urandom % 3) == 0;
         ix = 3'($urandom % 8);
         d  = 8'($urandom);
         if (we && ix == 3'd0 && ($urandom % 2) == 0) d = d & 8'h04;
         if (we && ix == 3'd5 && ($urandom % 4) != 0) we = 1'b0;
         h = 4'($urandom) & 4'($urandom) & 4'($urandom);
         r = 4'($urandom) & 4'($urandom) & 4'($urandom);
         t = 4'($urandom) & 4'($urandom);
         step(we, re, ix, d, h, r, t);
      end
      step(0, 0, 3'd0, 8'h00, 0, 0, 0);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule